// File: doc/BRIEF.md
# Line Signal Loss Detector

This block watches a received serial bit stream, one bit per strobe on `bit_vld`, and decides whether the line has gone dead. A long unbroken run of zero bits puts it into the loss state. It leaves that state only when the stream again looks like a live line. That means a full observation window with enough marks in it and no very long silent gap inside the window. A single stray one is not enough to leave.

While the loss flag is raised, the block forces its copies of the received data to zero. This covers both the positive and negative rails of a bipolar receiver and the single unipolar data bit. Logic downstream therefore sees a quiet line instead of noise. The flag itself is registered. The squelched data is the live input gated by that flag, so it adds no latency.

Clock recovery, holdover and jitter filtering belong to neighbouring blocks. This block assumes the strobe marks each recovered bit exactly once.

Top module: `los_monitor`

## Requirements
- R1: `los` rises on the clock edge that samples the ENTRY_ZEROS-th (default 175) consecutive strobed zero on `rx_bit`, and is visible from that edge on.
- R2: A strobed one on `rx_bit` resets the zero run, so 174 zeros followed by a one leave `los` at 0.
- R3: While `los` is 1, exit is judged over windows of EXIT_WINDOW strobed bits (default 175; legal 100 to 250). The first window begins with the first strobed bit after entry, and each later window begins with the bit after a failed window or a restart.
- R4: On the last bit of a window, `los` falls if ones×8 ≥ EXIT_WINDOW, counting that last bit (22 of 175 passes, 21 fails). Otherwise a fresh window starts on the next bit.
- R5: A strobed zero that makes the run of consecutive zeros longer than MAX_ZERO_RUN (100) restarts the window. That zero is not counted, and the ones seen so far are discarded.
- R6: A run of exactly 100 consecutive zeros inside a window does not restart it.
- R7: While `los` is 1, `sq_pos`, `sq_neg` and `sq_bit` are 0 whatever the inputs.
- R8: While `los` is 0, `sq_pos`, `sq_neg` and `sq_bit` equal `rx_pos`, `rx_neg` and `rx_bit` in the same cycle.
- R9: In cycles with `bit_vld` low, no counter advances and `los` does not change.
- R10: A synchronous active-low `rst_n` forces `los` to 0 and clears the zero run and window state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | Strobe: one received bit period is present |
| rx_bit | input | 1 | Received bit (1 = mark); drives detection and the unipolar output |
| rx_pos | input | 1 | Positive rail of the bipolar receive pair |
| rx_neg | input | 1 | Negative rail of the bipolar receive pair |
| los | output | 1 | Loss-of-signal flag |
| sq_pos | output | 1 | Squelched positive rail |
| sq_neg | output | 1 | Squelched negative rail |
| sq_bit | output | 1 | Squelched unipolar data |

## Verification
The assertions check the cycle-level rules on every clock:
- the outputs are squelched or passed through according to the flag;
- the flag holds steady without a strobe;
- a strobed one never causes entry;
- entry happens exactly when an independently kept zero-run count reaches its limit;
- the flag only falls on a strobe;
- reset clears the flag.

The density rule, the window length and the effect of over-long zero runs inside a window depend on whole bit sequences. Only the bench's scenarios show them. These scenarios are:
- windows with 21 and with 22 marks;
- a 101-zero gap that discards the marks seen before it;
- a 100-zero gap that is allowed.

// File: rtl/los_pkg.sv
// Package: shared types for the loss-of-signal detector.
// Assumes nothing beyond IEEE 1800-2017.
package los_pkg;

    // Line condition held by the state controller.
    typedef enum logic {
        ST_ACTIVE = 1'b0,
        ST_LOST   = 1'b1
    } los_state_e;

    // Larger of two integers, used to size shared counters.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/los_zero_run.sv
// Counts consecutive strobed zero bits.
// A strobed one returns the count to zero. The count saturates at SAT_MAX,
// so it never wraps. Assumes the strobe marks each bit period once.
module los_zero_run #(
    parameter int SAT_MAX = 175,
    parameter int RUN_W   = $clog2(SAT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             rx_bit,
    output logic [RUN_W-1:0] run_cnt
);
    localparam logic [RUN_W-1:0] SAT_VAL = RUN_W'(SAT_MAX);

    // Purpose: track the current zero run, holding still between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (bit_vld) begin
            if (rx_bit) begin
                run_cnt <= '0;
            end else if (run_cnt != SAT_VAL) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/los_exit_window.sv
// Judges whether the line has recovered while the loss state is armed.
// Strobed bits are gathered into windows of WINDOW bits.
// - On the last bit of a window, exit_ok pulses if the window's marks times
//   DENS_DIV reach WINDOW.
// - A zero that pushes the consecutive-zero run past MAX_RUN restarts the
//   window and is not counted.
// Assumes run_cnt is the registered run length before the current bit.
module los_exit_window #(
    parameter int WINDOW   = 175,
    parameter int MAX_RUN  = 100,
    parameter int DENS_DIV = 8,
    parameter int RUN_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             bit_vld,
    input  logic             rx_bit,
    input  logic [RUN_W-1:0] run_cnt,
    output logic             exit_ok
);
    localparam int               CNT_W    = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW - 1);
    localparam logic [RUN_W-1:0] RUN_CAP  = RUN_W'(MAX_RUN);
    localparam logic [31:0]      NEED     = 32'(WINDOW);
    localparam logic [31:0]      DIV      = 32'(DENS_DIV);

    logic [CNT_W-1:0] bit_idx;
    logic [CNT_W-1:0] ones_q;
    logic [CNT_W-1:0] ones_nxt;
    logic             restart;
    logic             last_bit;
    logic             dens_ok;

    // Purpose: decode restart, window end and the density test for this bit.
    always_comb begin
        restart  = bit_vld && !rx_bit && (run_cnt >= RUN_CAP);
        last_bit = (bit_idx == LAST_IDX);
        ones_nxt = ones_q + CNT_W'(rx_bit);
        dens_ok  = (32'(ones_nxt) * DIV) >= NEED;
        exit_ok  = arm && bit_vld && !restart && last_bit && dens_ok;
    end

    // Purpose: advance the window position and mark count on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            bit_idx <= '0;
            ones_q  <= '0;
        end else if (bit_vld) begin
            if (restart || last_bit) begin
                bit_idx <= '0;
                ones_q  <= '0;
            end else begin
                bit_idx <= bit_idx + 1'b1;
                ones_q  <= ones_nxt;
            end
        end
    end
endmodule

// File: rtl/los_state_ctl.sv
// Holds the line condition.
// - Moves to the loss state when the strobed bit is the ENTRY_ZEROS-th
//   consecutive zero.
// - Returns to active when the exit window reports recovery.
// Assumes run_cnt is the run length before the current bit.
module los_state_ctl
    import los_pkg::*;
#(
    parameter int ENTRY_ZEROS = 175,
    parameter int RUN_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             rx_bit,
    input  logic [RUN_W-1:0] run_cnt,
    input  logic             exit_ok,
    output logic             lost
);
    localparam logic [RUN_W-1:0] ENTRY_PRE = RUN_W'(ENTRY_ZEROS - 1);

    los_state_e state_q;
    los_state_e state_d;

    // Purpose: choose the next line condition from this strobe.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (bit_vld && !rx_bit && (run_cnt >= ENTRY_PRE)) state_d = ST_LOST;
            ST_LOST:   if (exit_ok) state_d = ST_ACTIVE;
            default:   state_d = ST_ACTIVE;
        endcase
    end

    // Purpose: register the line condition.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    assign lost = (state_q == ST_LOST);
endmodule

// File: rtl/los_squelch.sv
// Forces each data lane to zero while the loss flag is set.
// Otherwise the lanes pass through unchanged. Purely combinational.
module los_squelch #(
    parameter int LANES = 3
) (
    input  logic             lost,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);
    // One gate per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g] = din[g] & ~lost;
    end
endmodule

// File: rtl/los_monitor.sv
// Top of the loss-of-signal detector.
// - A shared zero-run counter feeds both the entry rule and the
//   zero-gap limit of the exit windows.
// - The state controller registers the flag.
// - The squelch gates the received rails and the unipolar bit.
// Assumes one strobe per received bit period.
// EXIT_WINDOW is meant to lie within 100..250.
module los_monitor
    import los_pkg::*;
#(
    parameter int ENTRY_ZEROS = 175,
    parameter int EXIT_WINDOW = 175,
    parameter int MAX_ZERO_RUN = 100,
    parameter int DENS_DIV    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic rx_bit,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic los,
    output logic sq_pos,
    output logic sq_neg,
    output logic sq_bit
);
    localparam int SAT_MAX = max_int(ENTRY_ZEROS, MAX_ZERO_RUN);
    localparam int RUN_W   = $clog2(SAT_MAX + 1);
    localparam int LANES   = 3;

    logic [RUN_W-1:0] run_cnt;
    logic             exit_ok;
    logic             lost;
    logic [LANES-1:0] lane_in;
    logic [LANES-1:0] lane_out;

    los_zero_run #(.SAT_MAX(SAT_MAX), .RUN_W(RUN_W)) u_run (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
        .run_cnt(run_cnt)
    );

    los_exit_window #(
        .WINDOW(EXIT_WINDOW), .MAX_RUN(MAX_ZERO_RUN),
        .DENS_DIV(DENS_DIV), .RUN_W(RUN_W)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .arm(lost), .bit_vld(bit_vld),
        .rx_bit(rx_bit), .run_cnt(run_cnt), .exit_ok(exit_ok)
    );

    los_state_ctl #(.ENTRY_ZEROS(ENTRY_ZEROS), .RUN_W(RUN_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
        .run_cnt(run_cnt), .exit_ok(exit_ok), .lost(lost)
    );

    assign lane_in = {rx_pos, rx_neg, rx_bit};

    los_squelch #(.LANES(LANES)) u_sq (
        .lost(lost), .din(lane_in), .dout(lane_out)
    );

    assign los    = lost;
    assign sq_pos = lane_out[2];
    assign sq_neg = lane_out[1];
    assign sq_bit = lane_out[0];
endmodule

// File: rtl/los_monitor_chk.sv
// Checker for los_monitor, observing its ports only.
// Keeps its own count of consecutive strobed zeros to judge entry.
module los_monitor_chk #(
    parameter int ENTRY_ZEROS = 175
) (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic rx_bit,
    input logic rx_pos,
    input logic rx_neg,
    input logic los,
    input logic sq_pos,
    input logic sq_neg,
    input logic sq_bit
);
    localparam int              CW   = $clog2(ENTRY_ZEROS + 1);
    localparam logic [CW-1:0]   FULL = CW'(ENTRY_ZEROS);

    logic [CW-1:0] ck_run;

    // Purpose: independent zero-run count, saturating at the entry limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ck_run <= '0;
        else if (bit_vld && rx_bit)        ck_run <= '0;
        else if (bit_vld && ck_run != FULL) ck_run <= ck_run + 1'b1;
    end

    a_r7_squelch: assert property (@(posedge clk) disable iff (!rst_n)
        los |-> (!sq_pos && !sq_neg && !sq_bit));

    a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !los |-> (sq_pos == rx_pos && sq_neg == rx_neg && sq_bit == rx_bit));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(los));

    a_r1_entry_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> (ck_run == FULL));

    a_r2_one_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && bit_vld && rx_bit) |=> !los);

    a_r4_exit_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> $past(bit_vld));

    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> !los);
endmodule

bind los_monitor los_monitor_chk #(.ENTRY_ZEROS(ENTRY_ZEROS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .los(los),
    .sq_pos(sq_pos), .sq_neg(sq_neg), .sq_bit(sq_bit)
);

// File: tb/sim_los_monitor.sv
module sim_los_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0, rx_bit = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
    logic los, sq_pos, sq_neg, sq_bit;
    int   checks = 0, failures = 0;
    bit   done = 1'b0;
    logic ami_pol = 1'b0;

    always #10 clk = ~clk;

    los_monitor u0 (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .los(los),
        .sq_pos(sq_pos), .sq_neg(sq_neg), .sq_bit(sq_bit)
    );

    // Segment: count bits; a one at i = k*period for k < nones; expected los after.
    typedef struct packed {
        logic [11:0] count;
        logic [7:0]  period;
        logic [7:0]  nones;
        logic        exp_los;
    } seg_t;

    localparam int NSEG = 17;
    localparam seg_t SEGS [NSEG] = '{
        '{12'd174, 8'd1,   8'd0,   1'b0},  // 0  R2 174 zeros: no entry
        '{12'd1,   8'd1,   8'd1,   1'b0},  // 1  R2 one clears run
        '{12'd175, 8'd1,   8'd0,   1'b1},  // 2  R1 exactly 175 zeros
        '{12'd175, 8'd8,   8'd21,  1'b1},  // 3  R4 21 marks fail
        '{12'd174, 8'd8,   8'd22,  1'b1},  // 4  R3 window not yet full
        '{12'd1,   8'd1,   8'd0,   1'b0},  // 5  R4 22 marks on bit 175
        '{12'd1,   8'd1,   8'd1,   1'b0},  // 6  R1 prepare
        '{12'd175, 8'd1,   8'd0,   1'b1},  // 7  R1 re-entry
        '{12'd102, 8'd200, 8'd1,   1'b1},  // 8  R5 one then 101 zeros
        '{12'd73,  8'd3,   8'd21,  1'b1},  // 9  R5 blocked exit
        '{12'd101, 8'd1,   8'd101, 1'b1},  // 10 R5 new window at 174
        '{12'd1,   8'd1,   8'd1,   1'b0},  // 11 R5 new window completes
        '{12'd1,   8'd1,   8'd1,   1'b0},  // 12 R1 prepare
        '{12'd175, 8'd1,   8'd0,   1'b1},  // 13 R1 re-entry
        '{12'd101, 8'd200, 8'd1,   1'b1},  // 14 R6 one then 100 zeros
        '{12'd73,  8'd1,   8'd73,  1'b1},  // 15 R6 at 174 bits
        '{12'd1,   8'd1,   8'd1,   1'b0}   // 16 R6 exit, gap allowed
    };

    function automatic string seg_req(input int i);
        case (i)
            0, 1:             return "R2";
            2, 6, 7, 12, 13:  return "R1";
            3, 5:             return "R4";
            4:                return "R3";
            8, 9, 10, 11:     return "R5";
            default:          return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One strobed bit with AMI rails; returns at the following negedge.
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        rx_bit  = b;
        rx_pos  = b & ~ami_pol;
        rx_neg  = b & ami_pol;
        if (b) ami_pol = ~ami_pol;
        @(negedge clk);
        bit_vld = 1'b0;
        rx_bit = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R10 reset los", los, 1'b0);

        // R8 passthrough while no loss
        @(negedge clk);
        rx_pos = 1'b1; rx_neg = 1'b0; rx_bit = 1'b1;
        #1 check("R8 pos", sq_pos, 1'b1);
        check("R8 neg", sq_neg, 1'b0);
        check("R8 bit", sq_bit, 1'b1);
        rx_pos = 1'b0; rx_neg = 1'b1; rx_bit = 1'b0;
        #1 check("R8 neg2", sq_neg, 1'b1);
        check("R8 pos2", sq_pos, 1'b0);
        rx_neg = 1'b0;

        // Table of segments
        for (int s = 0; s < NSEG; s++) begin
            for (int i = 0; i < int'(SEGS[s].count); i++) begin
                send_bit((i % int'(SEGS[s].period) == 0) &&
                         (i / int'(SEGS[s].period) < int'(SEGS[s].nones)));
            end
            check(seg_req(s), los, SEGS[s].exp_los);
        end

        // R7 squelch while lost
        send_zeros(175);
        check("R7 entered", los, 1'b1);
        @(negedge clk);
        rx_pos = 1'b1; rx_neg = 1'b1; rx_bit = 1'b1;
        #1 check("R7 pos", sq_pos, 1'b0);
        check("R7 neg", sq_neg, 1'b0);
        check("R7 bit", sq_bit, 1'b0);
        // R9 unstrobed ones leave loss untouched
        repeat (300) @(negedge clk);
        check("R9 hold lost", los, 1'b1);
        rx_pos = 1'b0; rx_neg = 1'b0; rx_bit = 1'b0;

        // R10 reset mid-loss clears flag and run
        do_reset();
        check("R10 cleared", los, 1'b0);
        send_zeros(174);
        check("R10 run restarted", los, 1'b0);
        // R9 unstrobed zeros do not advance the run
        repeat (40) @(negedge clk);
        check("R9 no advance", los, 1'b0);
        send_bit(1'b0);
        check("R9 entry after strobe", los, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule